// File: doc/BRIEF.md
# Answer-to-Reset Convention Detector

This block sits in the receive path of a smart-card interface. It works out which coding convention the card uses. Software arms the detector with a one-cycle write pulse before the card answers reset. The first character that starts while the detector is armed is then captured by sampling the line in the middle of each bit time. That capture happens against a half-ETU tick that begins counting at the start-bit detect pulse. At the fixed point 10.5 ETU after the start bit, the detector compares the captured levels against the two legal opening patterns. It writes the convention bit, drops the arm bit and reports a mismatch on an error flag.

Every character that follows passes through the same sampler. Each is decoded with the convention in force: direct coding takes levels as they arrive, least significant bit first, with a high level read as 1. Inverse coding inverts every level and takes the first bit as the most significant. Each decoded byte is handed to the receive register with a one-cycle valid pulse at the same 10.5 ETU point. An auto-disable input hands ownership of the convention bit to software alone.

The controller has four states. IDLE waits for a start detect and goes to START. START waits one half-ETU tick. If the line is low, START goes to DATA. If the line is high, the start is rejected and START returns to IDLE. DATA samples eight bits and goes to GUARD after the last one. GUARD waits out the parity bit, then fires the resolve action and returns to IDLE.

Top module: `ts_conv_detect`

## Requirements
- R1: After reset the convention bit reads 1 (direct), and the arm bit, the error flag and the valid pulse read 0.
- R2: A pulse on `arm_wr` sets `arm`. An armed character clears `arm` at the clock edge of the 21st half-ETU tick after its start detect (10.5 ETU), whatever the character's value.
- R3: With `auto_off` at 0, a first character whose sampled levels, read least significant bit first with high as 1, equal 0x3B sets `conv` to 1 at the 10.5 ETU point.
- R4: With `auto_off` at 0, a first character whose inverted levels, read first bit as most significant, equal 0x3F sets `conv` to 0 at the 10.5 ETU point. These are the levels that read 0x03 under direct coding.
- R5: A first character that matches neither pattern leaves `conv` unchanged and sets `det_err`. The arm bit is still cleared. `det_err` stays set until the next `arm_wr` pulse clears it.
- R6: With `auto_off` at 1, the detector never changes `conv`, yet still clears `arm` at 10.5 ETU.
- R7: Data bit k (k = 0..7) is the line level at the (2k+3)-th half-ETU tick after start detect. Line levels at all other ticks have no effect on the result.
- R8: If the line is high at the first half-ETU tick, the start is abandoned. No valid pulse follows, and `arm`, `conv` and `det_err` keep their values.
- R9: Every accepted character gives a single-cycle `rx_valid` pulse at the 10.5 ETU point. `rx_data` holds the levels as-is when the convention is 1, and holds them inverted and bit-reversed when it is 0. An armed character is decoded with the convention it has just resolved.
- R10: A `conv_wr` pulse loads `conv_wdata` into `conv` at any time. It wins over a hardware update in the same cycle.
- R11: A start detect that arrives while a character is in progress is ignored.
- R12: A character that starts while `arm` is 0 never changes `conv` or `det_err`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| line_in | input | 1 | Synchronised I/O line level |
| half_etu | input | 1 | One-cycle pulse every half ETU, phase-aligned to the start detect |
| start_seen | input | 1 | One-cycle pulse when a falling start edge is found |
| arm_wr | input | 1 | Software pulse that sets the arm bit and clears the error flag |
| conv_wr | input | 1 | Software write strobe for the convention bit |
| conv_wdata | input | 1 | Value written by `conv_wr` |
| auto_off | input | 1 | 1: only software owns the convention bit |
| conv | output | 1 | Convention: 1 direct, 0 inverse |
| arm | output | 1 | Detection armed; clears itself after the armed character |
| det_err | output | 1 | First character matched neither opening pattern |
| rx_valid | output | 1 | One-cycle pulse with a decoded character |
| rx_data | output | 8 | Decoded character |

## Verification
Every 8-bit level pattern is sent as an armed first character with auto-detection on. Exactly two of them must change the convention, and every other pattern must raise the error flag. This separates a correct comparison from one that ignores bit order or polarity. The same sweep is repeated with auto-detection off, to show that the convention holds while the arm bit still clears. All 256 patterns are then sent unarmed under each convention, so a missing inversion or reversal in the decoder shows up in the data. The line is flipped between sampling ticks in every character, which exposes sampling at the wrong tick. Separate cases cover a rejected start, a second start detect in mid-character, and a software write that lands on the resolve edge.

// File: rtl/ts_conv_pkg.sv
package ts_conv_pkg;

    // Default character width on the line (data bits only)
    localparam int CHAR_BITS_DEF = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_GUARD
    } det_state_e;

endpackage

// File: rtl/ts_bit_sampler.sv
// Half-ETU tick counter and mid-bit shift register for one character.
module ts_bit_sampler #(
    parameter int CHAR_BITS = 8,
    parameter int CNT_W     = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 tick,
    input  logic                 line_in,
    output logic [CNT_W-1:0]     tick_cnt,
    output logic [CHAR_BITS-1:0] raw_bits
);
    localparam int FIRST_SAMPLE = 2;
    localparam int LAST_SAMPLE  = 2 * CHAR_BITS;

    logic sample_now;

    // Ticks already counted: even values 2..2*CHAR_BITS fall on bit centres
    assign sample_now = tick && !clr && !tick_cnt[0]
                        && (tick_cnt >= CNT_W'(FIRST_SAMPLE))
                        && (tick_cnt <= CNT_W'(LAST_SAMPLE));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            raw_bits <= '0;
        end else begin
            if (clr) begin
                tick_cnt <= '0;
            end else if (tick) begin
                tick_cnt <= tick_cnt + CNT_W'(1);
            end
            // First level received ends up in bit 0
            if (sample_now) begin
                raw_bits <= {line_in, raw_bits[CHAR_BITS-1:1]};
            end
        end
    end

endmodule

// File: rtl/ts_pattern_match.sv
// Compares captured levels with both opening patterns and decodes the character.
module ts_pattern_match #(
    parameter int                   CHAR_BITS    = 8,
    parameter logic [CHAR_BITS-1:0] DIRECT_CODE  = 8'h3B,
    parameter logic [CHAR_BITS-1:0] INVERSE_CODE = 8'h3F
) (
    input  logic [CHAR_BITS-1:0] raw_bits,
    input  logic                 cur_conv,
    input  logic                 allow,
    output logic                 hit_direct,
    output logic                 hit_inverse,
    output logic                 adopt,
    output logic [CHAR_BITS-1:0] dec_data
);
    logic [CHAR_BITS-1:0] inv_view;
    logic                 eff_conv;

    // Inverse reading: complement of each level, first level is the MSB
    for (genvar i = 0; i < CHAR_BITS; i++) begin : g_mirror
        assign inv_view[i] = ~raw_bits[CHAR_BITS-1-i];
    end

    always_comb begin
        hit_direct  = (raw_bits == DIRECT_CODE);
        hit_inverse = (inv_view == INVERSE_CODE);
        adopt       = allow && (hit_direct || hit_inverse);
        eff_conv    = adopt ? hit_direct : cur_conv;
        dec_data    = eff_conv ? raw_bits : inv_view;
    end

endmodule

// File: rtl/ts_conv_detect.sv
// Convention detector: control FSM, status bits and receive register.
module ts_conv_detect
    import ts_conv_pkg::*;
#(
    parameter int                   CHAR_BITS    = CHAR_BITS_DEF,
    parameter logic [CHAR_BITS-1:0] DIRECT_CODE  = 8'h3B,
    parameter logic [CHAR_BITS-1:0] INVERSE_CODE = 8'h3F
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_in,
    input  logic                 half_etu,
    input  logic                 start_seen,
    input  logic                 arm_wr,
    input  logic                 conv_wr,
    input  logic                 conv_wdata,
    input  logic                 auto_off,
    output logic                 conv,
    output logic                 arm,
    output logic                 det_err,
    output logic                 rx_valid,
    output logic [CHAR_BITS-1:0] rx_data
);
    // start bit + data bits + parity, then half a bit more
    localparam int RESOLVE_HALF = 2 * (CHAR_BITS + 2) + 1;
    localparam int CNT_W        = $clog2(RESOLVE_HALF + 1);
    localparam int LAST_SAMPLE  = 2 * CHAR_BITS;
    localparam int DONE_CNT     = RESOLVE_HALF - 1;

    det_state_e           state_q, state_d;
    logic                 det_q;
    logic                 done;
    logic [CNT_W-1:0]     tick_cnt;
    logic [CHAR_BITS-1:0] raw_bits;
    logic                 hit_direct, hit_inverse, adopt;
    logic [CHAR_BITS-1:0] dec_data;

    ts_bit_sampler #(
        .CHAR_BITS (CHAR_BITS),
        .CNT_W     (CNT_W)
    ) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q == ST_IDLE),
        .tick     (half_etu),
        .line_in  (line_in),
        .tick_cnt (tick_cnt),
        .raw_bits (raw_bits)
    );

    ts_pattern_match #(
        .CHAR_BITS    (CHAR_BITS),
        .DIRECT_CODE  (DIRECT_CODE),
        .INVERSE_CODE (INVERSE_CODE)
    ) u_match (
        .raw_bits    (raw_bits),
        .cur_conv    (conv),
        .allow       (det_q && !auto_off),
        .hit_direct  (hit_direct),
        .hit_inverse (hit_inverse),
        .adopt       (adopt),
        .dec_data    (dec_data)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        done    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_seen) begin
                    state_d = ST_START;
                end
            end
            ST_START: begin
                if (half_etu) begin
                    state_d = line_in ? ST_IDLE : ST_DATA;
                end
            end
            ST_DATA: begin
                if (half_etu && (tick_cnt == CNT_W'(LAST_SAMPLE))) begin
                    state_d = ST_GUARD;
                end
            end
            ST_GUARD: begin
                if (half_etu && (tick_cnt == CNT_W'(DONE_CNT))) begin
                    state_d = ST_IDLE;
                    done    = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs and status bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            det_q    <= 1'b0;
            arm      <= 1'b0;
            conv     <= 1'b1;
            det_err  <= 1'b0;
            rx_valid <= 1'b0;
            rx_data  <= '0;
        end else begin
            rx_valid <= done;
            if (done) begin
                rx_data <= dec_data;
            end

            if ((state_q == ST_IDLE) && start_seen) begin
                det_q <= arm;
            end

            if (arm_wr) begin
                arm <= 1'b1;
            end else if (done && det_q) begin
                arm <= 1'b0;
            end

            if (arm_wr) begin
                det_err <= 1'b0;
            end else if (done && det_q && !hit_direct && !hit_inverse) begin
                det_err <= 1'b1;
            end

            if (conv_wr) begin
                conv <= conv_wdata;
            end else if (done && adopt) begin
                conv <= hit_direct;
            end
        end
    end

endmodule

// File: rtl/ts_conv_detect_chk.sv
module ts_conv_detect_chk (
    input logic clk,
    input logic rst_n,
    input logic conv,
    input logic arm,
    input logic det_err,
    input logic rx_valid,
    input logic conv_wr,
    input logic auto_off
);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (conv && !arm && !det_err && !rx_valid));

    // R2
    arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arm) |-> rx_valid);

    // R9
    rx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R5
    err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_err) |-> (rx_valid && !arm));

    // R5
    err_conv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_err) |-> ($stable(conv) || $past(conv_wr)));

    // R6
    auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(auto_off) && !$past(conv_wr)) |-> $stable(conv));

    // R12
    conv_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(conv) |-> (rx_valid || $past(conv_wr)));

endmodule

bind ts_conv_detect ts_conv_detect_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .conv     (conv),
    .arm      (arm),
    .det_err  (det_err),
    .rx_valid (rx_valid),
    .conv_wr  (conv_wr),
    .auto_off (auto_off)
);

// File: tb/ts_conv_detect_bench.sv
module ts_conv_detect_bench;

    logic       clk        = 1'b0;
    logic       rst_n      = 1'b0;
    logic       line_in    = 1'b1;
    logic       half_etu   = 1'b0;
    logic       start_seen = 1'b0;
    logic       arm_wr     = 1'b0;
    logic       conv_wr    = 1'b0;
    logic       conv_wdata = 1'b0;
    logic       auto_off   = 1'b0;
    logic       conv, arm, det_err, rx_valid;
    logic [7:0] rx_data;

    int errors = 0;
    int checks = 0;
    int pulses = 0;

    // bench model
    logic conv_m = 1'b1;
    logic arm_m  = 1'b0;
    logic err_m  = 1'b0;

    always #10 clk = ~clk;

    ts_conv_detect u_ts_conv_detect (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_in    (line_in),
        .half_etu   (half_etu),
        .start_seen (start_seen),
        .arm_wr     (arm_wr),
        .conv_wr    (conv_wr),
        .conv_wdata (conv_wdata),
        .auto_off   (auto_off),
        .conv       (conv),
        .arm        (arm),
        .det_err    (det_err),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data)
    );

    always @(negedge clk) if (rst_n && rx_valid) pulses++;

    function automatic logic [7:0] rev8(input logic [7:0] x);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = x[7-i];
        return r;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic do_arm();
        @(negedge clk); arm_wr = 1'b1;
        @(negedge clk); arm_wr = 1'b0;
        arm_m = 1'b1; err_m = 1'b0;
    endtask

    task automatic sw_conv(input logic v);
        @(negedge clk); conv_wr = 1'b1; conv_wdata = v;
        @(negedge clk); conv_wr = 1'b0;
        conv_m = v;
    endtask

    // Send one character; lv[k] is the line level of data bit k.
    task automatic send_char(input logic [7:0] lv, input bit bad_start,
                             input bit sw_wr, input logic sw_val,
                             input bit extra_start, input string req);
        logic det, hd, hi, adopt, eff;
        logic [7:0] exp_rx;
        int p0;
        det = arm_m;
        p0  = pulses;
        @(negedge clk); start_seen = 1'b1; line_in = 1'b0;
        @(negedge clk); start_seen = 1'b0;
        for (int t = 1; t <= 21; t++) begin
            if (t == 1)                            line_in = bad_start;
            else if (t >= 3 && t <= 17 && (t % 2)) line_in = lv[(t-3)/2];
            else if (t <= 18)                      line_in = ~line_in; // noise off-centre
            else                                   line_in = 1'b1;
            if (extra_start && t == 8) start_seen = 1'b1;
            if (sw_wr && t == 21) begin conv_wr = 1'b1; conv_wdata = sw_val; end
            half_etu = 1'b1;
            @(negedge clk);
            half_etu = 1'b0; start_seen = 1'b0; conv_wr = 1'b0;
            if (bad_start) break;
            if (t == 20) chk("R2", "arm before 10.5 ETU", arm, arm_m);
            if (t < 21) @(negedge clk);
        end
        if (bad_start) begin
            line_in = 1'b1;
            repeat (50) @(negedge clk);
            chk("R8", "no pulse", pulses - p0, 0);
            chk("R8", "arm kept", arm, arm_m);
            chk("R8", "conv kept", conv, conv_m);
            chk("R8", "err kept", det_err, err_m);
        end else begin
            hd = (lv == 8'h3B);
            hi = ((~rev8(lv)) == 8'h3F);
            adopt = det && !auto_off && (hd || hi);
            eff = adopt ? hd : conv_m;
            exp_rx = eff ? lv : ~rev8(lv);
            conv_m = sw_wr ? sw_val : (adopt ? hd : conv_m);
            if (det) arm_m = 1'b0;
            if (det && !(hd || hi)) err_m = 1'b1;
            chk("R9", {req, " valid"}, rx_valid, 1'b1);
            chk("R9", {req, " data"}, rx_data, exp_rx);
            chk(req, "conv", conv, conv_m);
            chk("R2", "arm", arm, arm_m);
            chk("R5", "det_err", det_err, err_m);
            @(negedge clk);
            chk("R9", "single pulse", pulses - p0, 1);
            line_in = 1'b1;
            repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1", "conv", conv, 1'b1);
        chk("R1", "arm", arm, 1'b0);
        chk("R1", "det_err", det_err, 1'b0);
        chk("R1", "rx_valid", rx_valid, 1'b0);

        // R10 idle software writes
        sw_conv(1'b0); chk("R10", "write 0", conv, 1'b0);
        sw_conv(1'b1); chk("R10", "write 1", conv, 1'b1);

        // R3 R4 R5 R7: every pattern as armed first character, auto on
        auto_off = 1'b0;
        for (int v = 0; v < 256; v++) begin
            do_arm();
            chk("R5", "err cleared by arm", det_err, 1'b0);
            chk("R2", "arm set", arm, 1'b1);
            send_char(8'(v), 1'b0, 1'b0, 1'b0, 1'b0, (v == 8'h3B) ? "R3" : ((v == 8'h03) ? "R4" : "R7"));
        end

        // R6: auto off, convention owned by software
        auto_off = 1'b1;
        for (int v = 0; v < 256; v++) begin
            if (v == 0)   sw_conv(1'b0);
            if (v == 128) sw_conv(1'b1);
            do_arm();
            send_char(8'(v), 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        end
        auto_off = 1'b0;

        // R12 R9: unarmed data under each convention
        sw_conv(1'b1);
        for (int v = 0; v < 256; v++) send_char(8'(v), 1'b0, 1'b0, 1'b0, 1'b0, "R12");
        sw_conv(1'b0);
        for (int v = 0; v < 256; v++) send_char(8'(v), 1'b0, 1'b0, 1'b0, 1'b0, "R12");

        // R8: rejected start leaves detection armed, next char still resolves
        sw_conv(1'b0);
        do_arm();
        send_char(8'h3B, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        send_char(8'h3B, 1'b0, 1'b0, 1'b0, 1'b0, "R3");

        // R11: second start detect mid-character is ignored
        do_arm();
        send_char(8'h03, 1'b0, 1'b0, 1'b0, 1'b1, "R11");
        chk("R11", "inverse adopted", conv, 1'b0);

        // R10: software write wins on the resolve edge
        do_arm();
        send_char(8'h03, 1'b0, 1'b1, 1'b1, 1'b0, "R10");
        chk("R10", "sw value kept", conv, 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule